// File: doc/BRIEF.md
# Interrupt Flag and Enable Controller

This block gathers interrupt requests for an 8051-style processor and presents seven request lines to the processor's priority and vectoring logic. Each line has a primary flag and a primary enable. The request for a line is raised while both are set. A primary flag clears on its own when the processor acknowledges that line's vector.

Three of the lines are shared with secondary event sources:
- line 2 is shared by two firmware-collision events;
- line 4 is shared by the rising and falling edges of the PLL-lock status;
- line 6 is shared by a transfer-busy event and a one-second tick.

Each secondary source has its own flag and its own enable. The enabled flags of a shared line are OR-ed together, and a rising edge of that OR sets the line's primary flag. A separate wake flag records a wake-timer timeout and raises no interrupt.

Software reaches the block through a small register port with byte writes and a combinational read. Secondary flags are cleared only by writing a zero to their bit position. Writing a one leaves a flag unchanged, so a byte of all ones with a single zero clears exactly one flag. Every raw input passes through a two-stage synchronizer before edge detection.

Top module: `irq_flag_ctrl`

Register map:

| Address | Name | Bits | Access | Function |
|---|---|---|---|---|
| 0 | primary enables | 6:0 | read/write | Enable for line n at bit n |
| 1 | primary flags | 6:0 | read only | Flag for line n at bit n; writes are ignored |
| 2 | control | 5:0 | read/write | Secondary enables: 0 transfer, 1 tick, 2 collision 0, 3 collision 1, 4 lock rise, 5 lock fall |
| 2 | control | 7:6 | read/write | Edge polarity: bit 6 for line 2, bit 7 for line 3 (0 = falling, 1 = rising) |
| 3 | secondary flags | 6:0 | read, write-zero-to-clear | Same order as the secondary enables, with bit 6 as the wake flag |

## Requirements
- R1: After reset all four registers read zero and irq_req is zero.
- R2: A primary flag is set by an edge on its pin, and reads 1 no more than four clock edges after the pin changes. The edge is falling for pins 0, 1, 5 and 6 (pins 5 and 6 are inverted, then rising-detected), and rising for pin 4. The opposite edge has no effect, and a held level sets nothing.
- R3: Control bit 6 (line 2) and control bit 7 (line 3) choose the edge for pins 2 and 3: 0 selects falling, 1 selects rising. Each reset value is 0.
- R4: irq_req[n] equals primary flag n AND primary enable n. An acknowledge with ack_num = n clears primary flag n.
- R5: A secondary flag is set by a rising edge of its event. The lock-fall flag (bit 5) is set by a falling edge of pll_lock. A held event level does not set a flag again.
- R6: Writing a byte to address 3 clears every secondary flag whose data bit is 0 and leaves every flag whose data bit is 1 unchanged.
- R7: For lines 2, 4 and 6, a rising edge of the OR of (secondary flag AND its enable) over the line's sources sets the primary flag. A source whose enable is 0 sets its own flag but does not set the primary flag.
- R8: While one source of a shared line is flagged and enabled, a second source being flagged produces no new primary flag. Clearing only one of the two flags produces no primary flag either.
- R9: A rising edge of wake_evt sets secondary flag bit 6. This flag never raises irq_req or any primary flag.
- R10: When a hardware set and a clear of the same flag fall in the same cycle, the flag ends set. This holds for a zero write against a secondary flag and for an acknowledge against a primary flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sfr_we | input | 1 | Register write strobe |
| sfr_addr | input | 2 | Register address |
| sfr_wdata | input | 8 | Write data |
| sfr_rdata | output | 8 | Read data for sfr_addr (combinational) |
| ext_pin | input | 7 | External interrupt pins, one per line |
| ev_xfer | input | 1 | Transfer-busy event |
| ev_tick | input | 1 | One-second tick event |
| ev_col0 | input | 1 | Firmware-collision event 0 |
| ev_col1 | input | 1 | Firmware-collision event 1 |
| pll_lock | input | 1 | PLL-lock status level |
| wake_evt | input | 1 | Wake-timer timeout |
| ack_valid | input | 1 | Vector acknowledge strobe |
| ack_num | input | 3 | Line number being acknowledged |
| irq_req | output | 7 | Request lines to the priority logic |

## Verification
Two pairs of functions can land on the same flag in the same cycle. A synchronized event edge can meet a zero write to the secondary flags, and a pin edge can meet a vector acknowledge of that line. The bench starts the event or pin change on a falling clock edge. Two falling edges later it issues the write or the acknowledge, so that both reach the flag register on the same rising edge. It then reads the flag back and expects it set, since a lost event would leave it clear.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;
  localparam int unsigned NLINE  = 7;
  localparam int unsigned NSEC   = 7;
  localparam int unsigned NSECEN = 6;
  localparam int unsigned NEV    = 6;
  localparam int unsigned SFRW   = 8;
  localparam int unsigned NUMW   = $clog2(NLINE);

  typedef enum logic [1:0] {
    A_PEN  = 2'd0,
    A_PFLG = 2'd1,
    A_SCTL = 2'd2,
    A_SFLG = 2'd3
  } sfr_addr_e;

  // secondary flag / enable bit positions
  localparam int S_XFER = 0;
  localparam int S_TICK = 1;
  localparam int S_COL0 = 2;
  localparam int S_COL1 = 3;
  localparam int S_PLLR = 4;
  localparam int S_PLLF = 5;
  localparam int S_WAKE = 6;

  // control register polarity bits
  localparam int C_POL2 = 6;
  localparam int C_POL3 = 7;
endpackage

// File: rtl/irq_sync_edge.sv
module irq_sync_edge #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] rise,
  output logic [W-1:0] fall
);
  localparam int unsigned LAST = STAGES - 1;

  logic [W-1:0] stg_q [STAGES];
  logic [W-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) stg_q[s] <= '0;
      prev_q <= '0;
    end else begin
      stg_q[0] <= din;
      for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
      prev_q <= stg_q[LAST];
    end
  end

  assign rise = stg_q[LAST] & ~prev_q;
  assign fall = ~stg_q[LAST] & prev_q;
endmodule

// File: rtl/irq_w0c_flags.sv
module irq_w0c_flags #(
  parameter int unsigned W = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] flag
);
  logic [W-1:0] flag_q, flag_d;

  always_comb begin
    flag_d = flag_q;
    if (wr) flag_d = flag_q & wdata;
    flag_d = flag_d | set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= '0;
    else        flag_q <= flag_d;
  end

  assign flag = flag_q;

  for (genvar i = 0; i < W; i++) begin : g_chk
    p_zero_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && !wdata[i] && !set[i]) |=> !flag_q[i]);
    p_one_keeps_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && wdata[i] && flag_q[i]) |=> flag_q[i]);
    p_set_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
      set[i] |=> flag_q[i]);
  end
endmodule

// File: rtl/irq_pri_flags.sv
module irq_pri_flags #(
  parameter int unsigned N  = 7,
  parameter int unsigned AW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  set,
  input  logic          ack_valid,
  input  logic [AW-1:0] ack_num,
  output logic [N-1:0]  flag
);
  logic [N-1:0] flag_q, flag_d, ack_dec;

  always_comb begin
    ack_dec = '0;
    for (int i = 0; i < N; i++)
      if (ack_valid && ack_num == AW'(i)) ack_dec[i] = 1'b1;
    flag_d = (flag_q & ~ack_dec) | set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= '0;
    else        flag_q <= flag_d;
  end

  assign flag = flag_q;

  for (genvar i = 0; i < N; i++) begin : g_chk
    p_ack_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_valid && ack_num == AW'(i) && !set[i]) |=> !flag_q[i]);
    p_set_beats_ack_r10: assert property (@(posedge clk) disable iff (!rst_n)
      set[i] |=> flag_q[i]);
    p_rise_has_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag_q[i]) |-> $past(set[i]));
  end
endmodule

// File: rtl/irq_flag_ctrl.sv
module irq_flag_ctrl
  import irq_ctrl_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sfr_we,
  input  logic [1:0]      sfr_addr,
  input  logic [SFRW-1:0] sfr_wdata,
  output logic [SFRW-1:0] sfr_rdata,
  input  logic [NLINE-1:0] ext_pin,
  input  logic            ev_xfer,
  input  logic            ev_tick,
  input  logic            ev_col0,
  input  logic            ev_col1,
  input  logic            pll_lock,
  input  logic            wake_evt,
  input  logic            ack_valid,
  input  logic [NUMW-1:0] ack_num,
  output logic [NLINE-1:0] irq_req
);
  // reset: asynchronous assert, synchronous release
  logic rst_meta_q, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  // software registers
  logic [NLINE-1:0] pen_q, pen_d;
  logic [SFRW-1:0]  sctl_q, sctl_d;
  logic             pen_we, sctl_we, sflg_we;

  assign pen_we  = sfr_we && (sfr_addr == A_PEN);
  assign sctl_we = sfr_we && (sfr_addr == A_SCTL);
  assign sflg_we = sfr_we && (sfr_addr == A_SFLG);

  always_comb begin
    pen_d  = pen_q;
    sctl_d = sctl_q;
    if (pen_we)  pen_d  = sfr_wdata[NLINE-1:0];
    if (sctl_we) sctl_d = sfr_wdata;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      pen_q  <= '0;
      sctl_q <= '0;
    end else begin
      pen_q  <= pen_d;
      sctl_q <= sctl_d;
    end
  end

  // synchronizers and edge detectors
  logic [NLINE-1:0] pin_rise, pin_fall;
  logic [NEV-1:0]   ev_raw, ev_rise, ev_fall;

  assign ev_raw = {wake_evt, pll_lock, ev_col1, ev_col0, ev_tick, ev_xfer};

  irq_sync_edge #(.W(NLINE), .STAGES(SYNC_STAGES)) u_pin_sync (
    .clk(clk), .rst_n(rst_sync_n), .din(ext_pin),
    .rise(pin_rise), .fall(pin_fall));

  irq_sync_edge #(.W(NEV), .STAGES(SYNC_STAGES)) u_ev_sync (
    .clk(clk), .rst_n(rst_sync_n), .din(ev_raw),
    .rise(ev_rise), .fall(ev_fall));

  // secondary flags
  logic [NSEC-1:0] sec_set, sec_flag;

  always_comb begin
    sec_set         = '0;
    sec_set[S_XFER] = ev_rise[0];
    sec_set[S_TICK] = ev_rise[1];
    sec_set[S_COL0] = ev_rise[2];
    sec_set[S_COL1] = ev_rise[3];
    sec_set[S_PLLR] = ev_rise[4];
    sec_set[S_PLLF] = ev_fall[4];
    sec_set[S_WAKE] = ev_rise[5];
  end

  irq_w0c_flags #(.W(NSEC)) u_sec (
    .clk(clk), .rst_n(rst_sync_n), .set(sec_set),
    .wr(sflg_we), .wdata(sfr_wdata[NSEC-1:0]), .flag(sec_flag));

  // shared-line merge: [0] line 2, [1] line 4, [2] line 6
  logic [NSECEN-1:0] sec_act;
  logic [2:0]        sh_req, sh_prev_q, sh_rise;

  assign sec_act   = sec_flag[NSECEN-1:0] & sctl_q[NSECEN-1:0];
  assign sh_req[0] = sec_act[S_COL0] | sec_act[S_COL1];
  assign sh_req[1] = sec_act[S_PLLR] | sec_act[S_PLLF];
  assign sh_req[2] = sec_act[S_XFER] | sec_act[S_TICK];
  assign sh_rise   = sh_req & ~sh_prev_q;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) sh_prev_q <= '0;
    else             sh_prev_q <= sh_req;
  end

  // primary line events
  logic [NLINE-1:0] line_evt, pri_flag;

  always_comb begin
    line_evt[0] = pin_fall[0];
    line_evt[1] = pin_fall[1];
    line_evt[2] = (sctl_q[C_POL2] ? pin_rise[2] : pin_fall[2]) | sh_rise[0];
    line_evt[3] = sctl_q[C_POL3] ? pin_rise[3] : pin_fall[3];
    line_evt[4] = pin_rise[4] | sh_rise[1];
    line_evt[5] = pin_fall[5];
    line_evt[6] = pin_fall[6] | sh_rise[2];
  end

  logic unused_edges;
  assign unused_edges = ^{pin_rise[6:5], pin_rise[1:0], pin_fall[4],
                          ev_fall[5], ev_fall[3:0], ev_rise[5]};

  irq_pri_flags #(.N(NLINE), .AW(NUMW)) u_pri (
    .clk(clk), .rst_n(rst_sync_n), .set(line_evt),
    .ack_valid(ack_valid), .ack_num(ack_num), .flag(pri_flag));

  assign irq_req = pri_flag & pen_q;

  always_comb begin
    sfr_rdata = '0;
    case (sfr_addr)
      A_PEN:   sfr_rdata[NLINE-1:0] = pen_q;
      A_PFLG:  sfr_rdata[NLINE-1:0] = pri_flag;
      A_SCTL:  sfr_rdata            = sctl_q;
      default: sfr_rdata[NSEC-1:0]  = sec_flag;
    endcase
  end

  p_line6_no_retrigger_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (sh_prev_q[2] && sh_req[2] && !pin_fall[6] && !ack_valid)
      |=> pri_flag[6] == $past(pri_flag[6]));
  p_line4_no_retrigger_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (sh_prev_q[1] && sh_req[1] && !pin_rise[4] && !ack_valid)
      |=> pri_flag[4] == $past(pri_flag[4]));
endmodule

// File: tb/irq_flag_ctrl_tb.sv
`timescale 1ns/1ps
module irq_flag_ctrl_tb;
  localparam logic [6:0] IDLE = 7'b1101111;

  typedef struct packed {
    logic [6:0] base;
    logic [6:0] pins;
    logic [1:0] pol;   // {line3, line2}
    logic [6:0] exp;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{IDLE,        7'b1101110, 2'b00, 7'h01},  // pin0 falling
    '{IDLE,        7'b1101101, 2'b00, 7'h02},  // pin1 falling
    '{IDLE,        7'b1101011, 2'b00, 7'h04},  // pin2 falling, pol falling
    '{IDLE,        7'b1101011, 2'b01, 7'h00},  // pin2 falling, pol rising
    '{7'b1101011,  IDLE,       2'b01, 7'h04},  // pin2 rising, pol rising
    '{IDLE,        7'b1100111, 2'b00, 7'h08},  // pin3 falling
    '{7'b1100111,  IDLE,       2'b10, 7'h08},  // pin3 rising, pol rising
    '{IDLE,        7'b1111111, 2'b00, 7'h10},  // pin4 rising
    '{7'b1111111,  IDLE,       2'b00, 7'h00},  // pin4 falling ignored
    '{IDLE,        7'b1001111, 2'b00, 7'h20},  // pin5 falling
    '{IDLE,        7'b0101111, 2'b00, 7'h40},  // pin6 falling
    '{7'b1001111,  IDLE,       2'b00, 7'h00}   // pin5 rising ignored
  };

  logic       clk = 1'b0;
  logic       rst_n;
  logic       sfr_we;
  logic [1:0] sfr_addr;
  logic [7:0] sfr_wdata, sfr_rdata;
  logic [6:0] ext_pin, irq_req;
  logic       ev_xfer, ev_tick, ev_col0, ev_col1, pll_lock, wake_evt;
  logic       ack_valid;
  logic [2:0] ack_num;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  irq_flag_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .sfr_we(sfr_we), .sfr_addr(sfr_addr),
    .sfr_wdata(sfr_wdata), .sfr_rdata(sfr_rdata), .ext_pin(ext_pin),
    .ev_xfer(ev_xfer), .ev_tick(ev_tick), .ev_col0(ev_col0), .ev_col1(ev_col1),
    .pll_lock(pll_lock), .wake_evt(wake_evt), .ack_valid(ack_valid),
    .ack_num(ack_num), .irq_req(irq_req));

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sfr_wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    sfr_we = 1'b1; sfr_addr = a; sfr_wdata = d;
    @(negedge clk);
    sfr_we = 1'b0;
  endtask

  task automatic sfr_rd(input logic [1:0] a, output logic [7:0] d);
    sfr_addr = a;
    #1;
    d = sfr_rdata;
  endtask

  task automatic ack(input logic [2:0] n);
    @(negedge clk);
    ack_valid = 1'b1; ack_num = n;
    @(negedge clk);
    ack_valid = 1'b0;
  endtask

  task automatic ack_all();
    for (int i = 0; i < 7; i++) ack(3'(i));
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    #1000000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [7:0] rd;
    rst_n = 1'b0; sfr_we = 1'b0; sfr_addr = 2'd0; sfr_wdata = 8'h00;
    ext_pin = IDLE; ev_xfer = 1'b0; ev_tick = 1'b0; ev_col0 = 1'b0;
    ev_col1 = 1'b0; pll_lock = 1'b0; wake_evt = 1'b0;
    ack_valid = 1'b0; ack_num = 3'd0;
    tick(4);
    rst_n = 1'b1;
    tick(4);

    // R1 reset state
    for (int a = 0; a < 4; a++) begin
      sfr_rd(2'(a), rd);
      check("R1 register reset", rd, 8'h00);
    end
    check("R1 irq_req reset", {1'b0, irq_req}, 8'h00);

    // R2/R3 pin edge table
    for (int v = 0; v < NV; v++) begin
      sfr_wr(2'd2, {VECS[v].pol, 6'b0});
      ext_pin = VECS[v].base;
      tick(5);
      ack_all();
      ext_pin = VECS[v].pins;
      tick(5);
      sfr_rd(2'd1, rd);
      check((v == 3 || v == 4 || v == 6) ? "R3 polarity table" : "R2 pin edge table",
            rd, {1'b0, VECS[v].exp});
      ext_pin = IDLE;
      tick(5);
      ack_all();
    end
    sfr_wr(2'd2, 8'h00);

    // R4 enable gating and acknowledge
    sfr_wr(2'd0, 8'h01);
    ext_pin = IDLE & ~7'h01;
    tick(5);
    check("R4 irq_req asserted", {1'b0, irq_req}, 8'h01);
    ack(3'd0);
    check("R4 irq_req after ack", {1'b0, irq_req}, 8'h00);
    sfr_rd(2'd1, rd);
    check("R4 flag cleared by ack", rd, 8'h00);
    ext_pin = IDLE;
    tick(5);
    check("R2 rising pin0 ignored", {1'b0, irq_req}, 8'h00);
    sfr_wr(2'd0, 8'h00);

    // R5/R7 transfer event on line 6
    sfr_wr(2'd2, 8'h01);
    ev_xfer = 1'b1;
    tick(6);
    sfr_rd(2'd3, rd);
    check("R5 xfer flag set", rd, 8'h01);
    sfr_rd(2'd1, rd);
    check("R7 line6 from xfer", rd, 8'h40);
    ack(3'd6);
    tick(6);
    sfr_rd(2'd1, rd);
    check("R5 held level no retrigger", rd, 8'h00);

    // R8 lock-up hazard, R6 write-zero clear
    sfr_wr(2'd2, 8'h03);
    ev_tick = 1'b1;
    tick(6);
    sfr_rd(2'd3, rd);
    check("R5 tick flag set", rd, 8'h03);
    sfr_rd(2'd1, rd);
    check("R8 second source no edge", rd, 8'h00);
    sfr_wr(2'd3, 8'hFE);
    sfr_rd(2'd3, rd);
    check("R6 single zero clears one", rd, 8'h02);
    sfr_rd(2'd1, rd);
    check("R8 partial clear no edge", rd, 8'h00);
    sfr_wr(2'd3, 8'hFF);
    sfr_rd(2'd3, rd);
    check("R6 ones leave flags", rd, 8'h02);
    sfr_wr(2'd3, 8'hFD);
    sfr_rd(2'd3, rd);
    check("R6 clear second flag", rd, 8'h00);
    ev_tick = 1'b0; ev_xfer = 1'b0;
    tick(4);
    ev_xfer = 1'b1;
    tick(7);
    sfr_rd(2'd1, rd);
    check("R7 new edge after clear", rd, 8'h40);
    ack(3'd6);
    ev_xfer = 1'b0;
    sfr_wr(2'd3, 8'h00);
    sfr_wr(2'd2, 8'h00);

    // R7 disabled source
    ev_col0 = 1'b1;
    tick(6);
    sfr_rd(2'd3, rd);
    check("R7 disabled source flags", rd, 8'h04);
    sfr_rd(2'd1, rd);
    check("R7 disabled source no line2", rd, 8'h00);
    ev_col0 = 1'b0;
    sfr_wr(2'd3, 8'h00);

    // R5 lock rise/fall on line 4
    sfr_wr(2'd2, 8'h30);
    pll_lock = 1'b1;
    tick(6);
    sfr_rd(2'd3, rd);
    check("R5 lock rise flag", rd, 8'h10);
    sfr_rd(2'd1, rd);
    check("R7 line4 from lock rise", rd, 8'h10);
    ack(3'd4);
    pll_lock = 1'b0;
    tick(6);
    sfr_rd(2'd3, rd);
    check("R5 lock fall flag", rd, 8'h30);
    sfr_rd(2'd1, rd);
    check("R8 line4 no second edge", rd, 8'h00);
    sfr_wr(2'd3, 8'h00);
    sfr_wr(2'd2, 8'h00);

    // R9 wake flag
    sfr_wr(2'd0, 8'h7F);
    sfr_wr(2'd2, 8'h3F);
    wake_evt = 1'b1;
    tick(6);
    sfr_rd(2'd3, rd);
    check("R9 wake flag set", rd, 8'h40);
    check("R9 wake raises no request", {1'b0, irq_req}, 8'h00);
    sfr_rd(2'd1, rd);
    check("R9 wake no primary flag", rd, 8'h00);
    sfr_wr(2'd3, 8'hBF);
    sfr_rd(2'd3, rd);
    check("R9 wake cleared by zero", rd, 8'h00);
    wake_evt = 1'b0;
    sfr_wr(2'd0, 8'h00);
    sfr_wr(2'd2, 8'h00);
    tick(4);

    // R10 secondary set against zero write in the same cycle
    @(negedge clk);
    ev_col0 = 1'b1;
    @(negedge clk);
    sfr_wr(2'd3, 8'h00);
    sfr_rd(2'd3, rd);
    check("R10 set beats zero write", rd, 8'h04);
    ev_col0 = 1'b0;
    sfr_wr(2'd3, 8'h00);

    // R10 primary set against acknowledge in the same cycle
    @(negedge clk);
    ext_pin = IDLE & ~7'h01;
    @(negedge clk);
    ack(3'd0);
    sfr_rd(2'd1, rd);
    check("R10 set beats ack", rd, 8'h01);
    ack(3'd0);
    ext_pin = IDLE;
    tick(5);

    finish_run();
  end
endmodule